// File: doc/BRIEF.md
# Nibble Register Transfer and Table-Lookup Unit

This block is one execution slice of a small 4-bit microcontroller core. It takes 10-bit instruction words and carries out four operations. The first splits the 8-bit register E into the nibble registers B and A. The second copies the 3-bit register D into the accumulator A. The third loads the 8-bit comparator register from B and A, but only while the comparator-mode bit is set. The fourth is a ROM table lookup. It parks the program counter on a hardware stack and reads one ROM byte from page p at the offset formed by D and A. It delivers that byte into B:A and then hands the saved PC back to the fetch unit.

Every other opcode is flagged as not handled, so that other slices can claim it. The single-word operations finish in the cycle in which they are presented. The lookup holds a busy line for two further cycles so that fetch stalls. While busy is high, new instruction words and stack-pointer loads are ignored. The core's own call and return logic can set the stack pointer through a load port while the unit is idle.

Top module: `nibble_xfer_unit`

## Requirements
- R1: Opcode 0x02A, accepted while idle, pulses a_we and b_we in the same cycle with a_out = e_in[3:0] and b_out = e_in[7:4]. It raises no other write strobe.
- R2: Opcode 0x051, accepted while idle, pulses a_we in the same cycle with a_out = {1'b0, d_in[2:0]}. It leaves b_we and cmp_we low.
- R3: Opcode 0x239 with cmp_mode = 1 pulses cmp_we with cmp_out = {b_in, a_in}. With cmp_mode = 0 it raises no write strobe and no not_handled.
- R4: Opcode 0x080 + p (p = 0..31) starts a lookup. In the next cycle busy = 1, sp_out is the starting value plus 1 (modulo 8), rom_rd = 1 and rom_addr = {p[4:0], d_in[2:0], a_in[3:0]}, all captured in the start cycle.
- R5: In the cycle after the ROM read, a_we and b_we pulse with a_out = rom_data[3:0] and b_out = rom_data[7:4]. pc_load pulses with pc_out equal to the pc_in value seen at the start. One cycle later busy = 0 and sp_out is back at its starting value.
- R6: A lookup that starts with the stack pointer at 7 wraps sp_out to 0 and sets stk_ovf. A lookup that starts below 7 clears stk_ovf. stk_ovf holds its value between lookups, and the PC is still returned correctly after a wrap.
- R7: Any other opcode accepted while idle raises not_handled in that cycle. It changes neither sp_out nor stk_ovf and raises no write, read or PC strobe.
- R8: While busy = 1, insn_valid and sp_load have no effect: no not_handled, no extra strobes, and the stack pointer follows only the lookup sequence.
- R9: sp_load while idle sets sp_out to sp_in on the next cycle. A lookup accepted in the same cycle pushes relative to the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word present |
| insn | input | 10 | Instruction word |
| pc_in | input | 12 | Current program counter |
| rom_data | input | 8 | ROM read data, one cycle after rom_rd |
| a_in | input | 4 | Register A value |
| b_in | input | 4 | Register B value |
| d_in | input | 3 | Register D value |
| e_in | input | 8 | Register E value |
| cmp_mode | input | 1 | Comparator-mode control bit |
| sp_load | input | 1 | Load stack pointer from sp_in |
| sp_in | input | 3 | Stack pointer load value |
| a_we | output | 1 | Write strobe for register A |
| a_out | output | 4 | New value for register A |
| b_we | output | 1 | Write strobe for register B |
| b_out | output | 4 | New value for register B |
| cmp_we | output | 1 | Write strobe for the comparator register |
| cmp_out | output | 8 | New comparator register value |
| pc_load | output | 1 | PC restore strobe |
| pc_out | output | 12 | Restored program counter |
| rom_rd | output | 1 | ROM read request |
| rom_addr | output | 12 | ROM read address {page, D, A} |
| sp_out | output | 3 | Stack pointer |
| stk_ovf | output | 1 | Last lookup wrapped the stack |
| busy | output | 1 | Lookup in progress, fetch must stall |
| not_handled | output | 1 | Accepted opcode not executed by this unit |

## Verification
The hardest state to reach from the ports is a stack overflow. Every lookup returns the stack pointer to where it started, so the pointer never drifts upward by itself. The stimulus uses the sp_load port to park the pointer at the top level, sometimes in the same cycle as the lookup start, and then checks that the pointer wraps, the flag rises and the PC still comes back intact. Random phases also keep instruction words and load requests arriving during busy, and check that they change nothing.

// File: rtl/nxu_pkg.sv
package nxu_pkg;

  typedef enum logic [2:0] {
    OP_UNK,
    OP_SPLIT,
    OP_LOOKUP,
    OP_DCOPY,
    OP_CMPW
  } nxu_op_e;

  localparam logic [9:0] OPC_SPLIT   = 10'h02A;
  localparam logic [9:0] OPC_DCOPY   = 10'h051;
  localparam logic [9:0] OPC_CMPW    = 10'h239;
  localparam logic [9:0] OPC_LK_BASE = 10'h080;

  function automatic logic [3:0] hi_nib(input logic [7:0] v);
    return v[7:4];
  endfunction

  function automatic logic [3:0] lo_nib(input logic [7:0] v);
    return v[3:0];
  endfunction

  // zero-extend the 3-bit D register into a nibble
  function automatic logic [3:0] widen_d(input logic [2:0] d);
    return {1'b0, d};
  endfunction

endpackage

// File: rtl/nxu_decode.sv
module nxu_decode
  import nxu_pkg::*;
#(
  parameter int PAGE_W = 5
) (
  input  logic [9:0]        insn,
  output nxu_op_e           op,
  output logic [PAGE_W-1:0] page
);
  localparam logic [9:0] LK_TAG = OPC_LK_BASE >> PAGE_W;

  assign page = insn[PAGE_W-1:0];

  always_comb begin
    if (insn == OPC_SPLIT)                op = OP_SPLIT;
    else if (insn == OPC_DCOPY)           op = OP_DCOPY;
    else if (insn == OPC_CMPW)            op = OP_CMPW;
    else if ((insn >> PAGE_W) == LK_TAG)  op = OP_LOOKUP;
    else                                  op = OP_UNK;
  end
endmodule

// File: rtl/nxu_stack.sv
module nxu_stack #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 12,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  input  logic            push,
  input  logic [PC_W-1:0] push_data,
  input  logic            pop,
  output logic [SP_W-1:0] sp,
  output logic [PC_W-1:0] top_data,
  output logic            push_wraps
);
  logic [PC_W-1:0] mem [DEPTH];
  logic [SP_W-1:0] sp_base;
  logic [SP_W-1:0] sp_up;

  assign sp_base    = load ? load_val : sp;
  assign sp_up      = sp_base + 1'b1;
  assign push_wraps = push && (sp_base == SP_W'(DEPTH - 1));
  assign top_data   = mem[sp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp_up] <= push_data;
      sp         <= sp_up;
    end else if (pop) begin
      sp <= sp - 1'b1;
    end else if (load) begin
      sp <= load_val;
    end
  end
endmodule

// File: rtl/nxu_lookup_seq.sv
module nxu_lookup_seq #(
  parameter int PAGE_W = 5,
  parameter int D_W    = 3,
  localparam int PC_W  = PAGE_W + D_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  input  logic [D_W-1:0]    d_val,
  input  logic [3:0]        a_val,
  output logic              busy,
  output logic              rd_phase,
  output logic              cap_phase,
  output logic [PC_W-1:0]   rom_addr
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_CAPT} seq_e;
  seq_e state;

  assign busy      = (state != S_IDLE);
  assign rd_phase  = (state == S_READ);
  assign cap_phase = (state == S_CAPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rom_addr <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          rom_addr <= {page, d_val, a_val};
          state    <= S_READ;
        end
        S_READ:  state <= S_CAPT;
        S_CAPT:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibble_xfer_unit.sv
module nibble_xfer_unit
  import nxu_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter int D_W    = 3,
  parameter int DEPTH  = 8,
  localparam int PC_W  = PAGE_W + D_W + 4,
  localparam int SP_W  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [9:0]      insn,
  input  logic [PC_W-1:0] pc_in,
  input  logic [7:0]      rom_data,
  input  logic [3:0]      a_in,
  input  logic [3:0]      b_in,
  input  logic [D_W-1:0]  d_in,
  input  logic [7:0]      e_in,
  input  logic            cmp_mode,
  input  logic            sp_load,
  input  logic [SP_W-1:0] sp_in,
  output logic            a_we,
  output logic [3:0]      a_out,
  output logic            b_we,
  output logic [3:0]      b_out,
  output logic            cmp_we,
  output logic [7:0]      cmp_out,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_out,
  output logic            rom_rd,
  output logic [PC_W-1:0] rom_addr,
  output logic [SP_W-1:0] sp_out,
  output logic            stk_ovf,
  output logic            busy,
  output logic            not_handled
);
  nxu_op_e           op;
  logic [PAGE_W-1:0] page;
  logic              accept;
  logic              do_split, do_dcopy, do_cmpw;
  logic              lk_start, lk_cap;
  logic              push_wraps;
  logic [PC_W-1:0]   saved_pc;

  nxu_decode #(.PAGE_W(PAGE_W)) dec_i (
    .insn (insn),
    .op   (op),
    .page (page)
  );

  assign accept      = insn_valid && !busy;
  assign do_split    = accept && (op == OP_SPLIT);
  assign do_dcopy    = accept && (op == OP_DCOPY);
  assign do_cmpw     = accept && (op == OP_CMPW) && cmp_mode;
  assign lk_start    = accept && (op == OP_LOOKUP);
  assign not_handled = accept && (op == OP_UNK);

  nxu_lookup_seq #(.PAGE_W(PAGE_W), .D_W(D_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (lk_start),
    .page      (page),
    .d_val     (d_in),
    .a_val     (a_in),
    .busy      (busy),
    .rd_phase  (rom_rd),
    .cap_phase (lk_cap),
    .rom_addr  (rom_addr)
  );

  nxu_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) stk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (sp_load && !busy),
    .load_val   (sp_in),
    .push       (lk_start),
    .push_data  (pc_in),
    .pop        (lk_cap),
    .sp         (sp_out),
    .top_data   (saved_pc),
    .push_wraps (push_wraps)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stk_ovf <= 1'b0;
    else if (lk_start) stk_ovf <= push_wraps;
  end

  assign a_we = do_split || do_dcopy || lk_cap;
  assign b_we = do_split || lk_cap;

  always_comb begin
    if (lk_cap)        a_out = lo_nib(rom_data);
    else if (do_split) a_out = lo_nib(e_in);
    else if (do_dcopy) a_out = widen_d(d_in);
    else               a_out = '0;
  end

  always_comb begin
    if (lk_cap)        b_out = hi_nib(rom_data);
    else if (do_split) b_out = hi_nib(e_in);
    else               b_out = '0;
  end

  assign cmp_we  = do_cmpw;
  assign cmp_out = do_cmpw ? {b_in, a_in} : 8'h00;
  assign pc_load = lk_cap;
  assign pc_out  = lk_cap ? saved_pc : '0;
endmodule

// File: rtl/nxu_checker.sv
module nxu_checker #(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_start,
  input logic            lk_cap,
  input logic            busy,
  input logic            rom_rd,
  input logic            a_we,
  input logic            b_we,
  input logic            cmp_we,
  input logic            cmp_mode,
  input logic            pc_load,
  input logic            not_handled,
  input logic            sp_load,
  input logic            stk_ovf,
  input logic [SP_W-1:0] sp_out
);
  a_r4_read_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    lk_start |=> busy && rom_rd && !pc_load);

  a_r5_capture_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cap |-> a_we && b_we && pc_load && !rom_rd);

  a_r5_sp_restored: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cap |=> !busy && (sp_out == SP_W'($past(sp_out) - 1'b1)));

  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    lk_start && !sp_load && (sp_out == SP_W'(DEPTH - 1)) |=> stk_ovf);

  a_r3_cmp_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> cmp_mode);

  a_r7_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    not_handled |-> !(a_we || b_we || cmp_we || rom_rd || pc_load));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !not_handled && !cmp_we && !lk_start);

  a_r5_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd, pc_load, lk_start}));
endmodule

bind nibble_xfer_unit nxu_checker #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_start    (lk_start),
  .lk_cap      (lk_cap),
  .busy        (busy),
  .rom_rd      (rom_rd),
  .a_we        (a_we),
  .b_we        (b_we),
  .cmp_we      (cmp_we),
  .cmp_mode    (cmp_mode),
  .pc_load     (pc_load),
  .not_handled (not_handled),
  .sp_load     (sp_load),
  .stk_ovf     (stk_ovf),
  .sp_out      (sp_out)
);

// File: tb/nibble_xfer_unit_tb.sv
module nibble_xfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [9:0]  insn = '0;
  logic [11:0] pc_in = '0;
  logic [7:0]  rom_data = '0;
  logic [3:0]  a_in = '0, b_in = '0;
  logic [2:0]  d_in = '0;
  logic [7:0]  e_in = '0;
  logic        cmp_mode = 1'b0;
  logic        sp_load = 1'b0;
  logic [2:0]  sp_in = '0;
  logic        a_we, b_we, cmp_we, pc_load, rom_rd, stk_ovf, busy, not_handled;
  logic [3:0]  a_out, b_out;
  logic [7:0]  cmp_out;
  logic [11:0] pc_out, rom_addr;
  logic [2:0]  sp_out;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;
  logic [2:0] sp_m = '0;
  logic       ovf_m = 1'b0;

  always #10 clk = ~clk;

  nibble_xfer_unit dut_i (.*);

  function automatic logic [7:0] rom_fn(input logic [11:0] a);
    return (a[7:0] * 8'h1D) ^ {a[11:8], a[3:0]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (rom_rd) rom_data <= rom_fn(rom_addr);

  function automatic bit is_known(input logic [9:0] w);
    return (w == 10'h02A) || (w == 10'h051) || (w == 10'h239) || (w[9:5] == 5'b00100);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  task automatic rand_regs();
    a_in = 4'($urandom); b_in = 4'($urandom);
    d_in = 3'($urandom); e_in = 8'($urandom);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    insn_valid = 0; sp_load = 0;
  endtask

  task automatic run_single(input logic [9:0] w, input logic mode);
    @(negedge clk);
    rand_regs();
    insn = w; insn_valid = 1; cmp_mode = mode; sp_load = 0;
    #2;
    if (w == 10'h02A) begin
      check("R1 a_we", a_we, 1); check("R1 b_we", b_we, 1);
      check("R1 a_out", a_out, e_in[3:0]); check("R1 b_out", b_out, e_in[7:4]);
      check("R1 cmp_we", cmp_we, 0);
    end else if (w == 10'h051) begin
      check("R2 a_we", a_we, 1); check("R2 a_out", a_out, {1'b0, d_in});
      check("R2 b_we", b_we, 0); check("R2 cmp_we", cmp_we, 0);
    end else if (w == 10'h239) begin
      check("R3 cmp_we", cmp_we, mode);
      if (mode) check("R3 cmp_out", cmp_out, {b_in, a_in});
      check("R3 a/b we", {a_we, b_we}, 0); check("R3 not_handled", not_handled, 0);
    end else begin
      check("R7 not_handled", not_handled, 1);
      check("R7 strobes", {a_we, b_we, cmp_we, rom_rd, pc_load}, 0);
    end
    @(negedge clk);
    insn_valid = 0;
    #2;
    check("R7 sp unchanged", sp_out, sp_m);
    check("R7 ovf unchanged", stk_ovf, ovf_m);
  endtask

  task automatic run_lookup(input logic [4:0] p, input bit load_same, input logic [2:0] ld_val);
    logic [11:0] pc_v, addr_v;
    logic [2:0]  base;
    @(negedge clk);
    rand_regs();
    pc_v = 12'($urandom);
    pc_in = pc_v; insn = 10'h080 + 10'(p); insn_valid = 1;
    sp_load = load_same; sp_in = ld_val;
    base = load_same ? ld_val : sp_m;
    addr_v = {p, d_in, a_in};
    #2;
    check("R4 idle before", busy, 0);
    @(negedge clk);
    insn = 10'($urandom); insn_valid = 1; sp_load = 1; sp_in = 3'($urandom);
    rand_regs(); pc_in = 12'($urandom); cmp_mode = 1;
    #2;
    check("R4 busy", busy, 1); check("R4 rom_rd", rom_rd, 1);
    check("R4 rom_addr", rom_addr, addr_v);
    check("R4 sp up", sp_out, 3'(base + 1));
    check("R6 ovf", stk_ovf, base == 3'd7);
    check("R8 no nh", {not_handled, cmp_we, a_we}, 0);
    @(negedge clk);
    insn = 10'h239;
    #2;
    check("R5 a_we b_we", {a_we, b_we}, 2'b11);
    check("R5 a_out", a_out, rom_fn(addr_v) & 8'h0F);
    check("R5 b_out", b_out, rom_fn(addr_v) >> 4);
    check("R5 pc_load", pc_load, 1); check("R5 pc_out", pc_out, pc_v);
    check("R8 no cmp", cmp_we, 0);
    @(negedge clk);
    insn_valid = 0; sp_load = 0;
    #2;
    check("R5 idle after", busy, 0); check("R5 sp back", sp_out, base);
    sp_m = base; ovf_m = (base == 3'd7);
  endtask

  task automatic load_sp(input logic [2:0] v);
    @(negedge clk);
    sp_load = 1; sp_in = v; insn_valid = 0;
    @(negedge clk);
    sp_load = 0;
    #2;
    check("R9 sp loaded", sp_out, v);
    sp_m = v;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check("reset sp", sp_out, 0); check("reset busy", busy, 0); check("reset ovf", stk_ovf, 0);
    run_single(10'h02A, 0);
    run_single(10'h051, 1);
    run_single(10'h239, 1);
    run_single(10'h239, 0);
    run_single(10'h3FF, 1);
    run_lookup(5'd0, 0, 0);
    run_lookup(5'd31, 0, 0);
    load_sp(3'd7);
    run_lookup(5'd9, 0, 0);        // R6 wrap from top level
    run_lookup(5'd2, 1, 3'd7);     // R9 load and lookup together, wraps too
    load_sp(3'd3);
    run_lookup(5'd17, 0, 0);       // R6 flag clears
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [9:0] w;
      k = int'($urandom % 6);
      case (k)
        0: run_single(10'h02A, 1'($urandom));
        1: run_single(10'h051, 1'($urandom));
        2: run_single(10'h239, 1'($urandom));
        3: begin
          do w = 10'($urandom); while (is_known(w));
          run_single(w, 1'($urandom));
        end
        4: run_lookup(5'($urandom), 1'($urandom % 4 == 0), 3'($urandom));
        default: load_sp(3'($urandom));
      endcase
    end
    idle_cycle();
    finish_run();
  end
endmodule